// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter that asks for a system reset when software stops servicing it. While the watchdog is enabled, the counter advances on every clock. If it reaches the timeout chosen by a two-bit rate select, the block raises a reset request for a single clock and starts counting again from zero.

Software services the watchdog through one 8-bit service register on a plain write port (address, data, strobe). The service takes two writes in a fixed order. An arming key of 0x55 readies the clear. A later clearing key of 0xAA then zeroes the counter and drops the armed state, so every service starts again with a fresh arming key. Any amount of other bus traffic may fall between the two keys. A clearing key written while the block is not armed does nothing.

Top module: `keyed_wdog`

## Requirements
- R1: A write of 0x55 to the service address (default 0x103A) puts the block in the armed state.
- R2: A write of 0xAA to the service address while armed clears the counter to zero and leaves the block unarmed.
- R3: Writes of values other than 0x55 and 0xAA to the service address, and writes of any value to any other address, leave the armed state unchanged, so the key sequence survives intervening traffic.
- R4: A write of 0xAA to the service address while unarmed leaves the counter unchanged and the block unarmed.
- R5: While enabled and not cleared, the counter raises the reset request after exactly 2^(BASE_EXP + 2*rate_sel) clock edges and then restarts from zero. With the default BASE_EXP of 15, rate_sel values 0, 1, 2 and 3 give 2^15, 2^17, 2^19 and 2^21 cycles.
- R6: The reset request is high for exactly one clock per timeout.
- R7: While wdog_en is low, the counter is held at zero and no reset request is raised.
- R8: When a valid clearing key lands in the same cycle as the terminal count, the clear wins and no reset request is raised.
- R9: After the synchronous reset, the reset request is low, the counter is zero and the block is unarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | 8 | Write data |
| wdog_en | input | 1 | Watchdog enable |
| rate_sel | input | 2 | Timeout select |
| rst_req | output | 1 | Registered one-clock reset request |

## Verification
A valid clearing key can arrive in the very cycle the counter reaches its terminal count, so a clear and a timeout then fall on the same edge. The bench provokes this on purpose: it arms the block and places the 0xAA write on the cycle its own model reports as the terminal count. It expects no reset request on that edge and a full timeout period afterwards. Random traffic makes the same collision happen at other rates, and a bench reference model that steps through the requirements judges every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef logic [7:0] key_t;
  localparam key_t KEY_ARM_DEF = 8'h55;
  localparam key_t KEY_CLR_DEF = 8'hAA;
  localparam int   NUM_RATES   = 4;
  localparam int   RATE_STEP   = 2;
  localparam int   SEL_W       = $clog2(NUM_RATES);
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SVC_ADDR = 16'h103A,
  parameter key_t        KEY_ARM  = KEY_ARM_DEF,
  parameter key_t        KEY_CLR  = KEY_CLR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  key_t              wr_data,
  output logic              clr_o,
  output logic              armed_o
);
  localparam logic [ADDR_W-1:0] MATCH = SVC_ADDR[ADDR_W-1:0];

  logic hit, arm_key, clr_key;

  assign hit     = wr_en && (wr_addr == MATCH);
  assign arm_key = hit && (wr_data == KEY_ARM);
  assign clr_key = hit && (wr_data == KEY_CLR);
  assign clr_o   = clr_key && armed_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
    end else if (arm_key) begin
      armed_o <= 1'b1;
    end else if (clr_o) begin
      armed_o <= 1'b0;
    end
  end

  // R1: arming key sets the armed state
  p_arm_set_r1: assert property (@(posedge clk) disable iff (rst)
    arm_key |=> armed_o);
  // R2: a completed clear drops the armed state
  p_clr_disarm_r2: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !armed_o);
  // R3: no key at the service address keeps the armed state
  p_other_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (!arm_key && !clr_key) |=> (armed_o == $past(armed_o)));
  // R4: clearing key while unarmed stays unarmed
  p_unarmed_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_key && !armed_o) |=> !armed_o);
endmodule

// File: rtl/wdog_rate_limit.sv
module wdog_rate_limit
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int CNT_W    = BASE_EXP + RATE_STEP*(NUM_RATES-1)
) (
  input  logic [SEL_W-1:0] rate_sel,
  output logic [CNT_W-1:0] term_o
);
  logic [CNT_W-1:0] term_tab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int EXP = BASE_EXP + RATE_STEP*g;
    assign term_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  assign term_o = term_tab[rate_sel];
endmodule

// File: rtl/wdog_timeout_ctr.sv
module wdog_timeout_ctr #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt;
  logic             at_term;

  assign at_term = (cnt >= term_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      req_o <= 1'b0;
    end else if (!en_i || clr_i) begin
      cnt   <= '0;
      req_o <= 1'b0;
    end else if (at_term) begin
      cnt   <= '0;
      req_o <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      req_o <= 1'b0;
    end
  end

  // R2: a clear leaves the counter at zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt == '0));
  // R5: the counter advances by one while running below terminal
  p_count_up_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && !at_term) |=> (cnt == $past(cnt) + 1'b1));
  // R5: a request comes with a restarted counter
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (cnt == '0));
  // R6: the request lasts one clock
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  // R7: a disabled watchdog raises no request
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!req_o && cnt == '0));
  // R8: a clear on the terminal edge suppresses the request
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && at_term) |=> !req_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SVC_ADDR = 16'h103A,
  parameter int          BASE_EXP = 15,
  parameter key_t        KEY_ARM  = KEY_ARM_DEF,
  parameter key_t        KEY_CLR  = KEY_CLR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wdog_en,
  input  logic [1:0]        rate_sel,
  output logic              rst_req
);
  localparam int CNT_W = BASE_EXP + RATE_STEP*(NUM_RATES-1);

  logic             svc_clr;
  logic             svc_armed;
  logic [CNT_W-1:0] term;

  wdog_key_seq #(
    .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR),
    .KEY_ARM(KEY_ARM), .KEY_CLR(KEY_CLR)
  ) u_keys (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_o(svc_clr), .armed_o(svc_armed)
  );

  wdog_rate_limit #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_rate (
    .rate_sel(rate_sel), .term_o(term)
  );

  wdog_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .en_i(wdog_en), .clr_i(svc_clr),
    .term_i(term), .req_o(rst_req)
  );

  // R9: reset leaves the block quiet and unarmed
  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!rst_req && !svc_armed));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;
  localparam int BEXP = 6;
  localparam logic [15:0] SVC = 16'h103A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wdog_en = 1'b0;
  logic [1:0] rate_sel = '0;
  logic rst_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_req = 0;

  always #4 clk = ~clk;

  keyed_wdog #(.BASE_EXP(BASE_EXP_T), .SVC_ADDR(SVC)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdog_en(wdog_en), .rate_sel(rate_sel),
    .rst_req(rst_req)
  );
  localparam int BASE_EXP_T = BEXP;

  function automatic int lim_of(input logic [1:0] s);
    return 1 << (BEXP + 2*int'(s));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock: inputs already driven; update model at edge, compare at negedge
  task automatic step();
    bit hit, clr;
    @(posedge clk);
    cyc++;
    hit = wr_en && (wr_addr == SVC);
    clr = hit && (wr_data == 8'hAA) && m_armed;
    if (rst) begin
      m_cnt = 0; m_armed = 0; m_req = 0;
    end else begin
      if (hit && wr_data == 8'h55) m_armed = 1;       // R1
      else if (clr) m_armed = 0;                        // R2
      if (!wdog_en || clr) begin m_cnt = 0; m_req = 0; end   // R7, R2, R8
      else if (m_cnt >= lim_of(rate_sel) - 1) begin m_cnt = 0; m_req = 1; end // R5
      else begin m_cnt++; m_req = 0; end
    end
    @(negedge clk);
    check(rst_req == m_req, "R5/R6/R8 rst_req vs model", int'(rst_req), int'(m_req));
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    idle();
  endtask

  task automatic do_reset();
    rst = 1; idle();
    repeat (3) step();
    check(rst_req == 1'b0, "R9 reset request low", int'(rst_req), 0);
    rst = 0;
  endtask

  // watchdog
  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    @(negedge clk);

    // R9 reset, then R5 exact timeout at rate 0
    wdog_en = 1; rate_sel = 0;
    do_reset();
    n = 0; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 64, "R5 timeout length rate 0", n, 64);
    step();
    check(rst_req == 0, "R6 request one clock", int'(rst_req), 0);

    // R5 rate 1 length
    rate_sel = 1;
    do_reset();
    n = 0; seen = 0;
    while (!seen && n < 1000) begin step(); n++; seen = rst_req; end
    check(n == 256, "R5 timeout length rate 1", n, 256);

    // R4 unarmed clear has no effect: timeout still at 64
    rate_sel = 0;
    do_reset();
    repeat (29) step();
    wr(SVC, 8'hAA);
    n = 30; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 64, "R4 unarmed 0xAA ignored", n, 64);

    // R1/R3/R2: arm, traffic between, clear at step 40 -> next timeout 64 later
    do_reset();
    repeat (10) step();
    wr(SVC, 8'h55);
    wr(SVC, 8'h12);
    wr(16'h1000, 8'hAA);
    wr(SVC + 16'd1, 8'h00);
    repeat (25) step();
    wr(SVC, 8'hAA);   // clear at the 40th edge
    n = 0; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 64, "R3 sequence survived traffic / R2 clear", n, 64);

    // R2: clear drops arm; a second 0xAA alone does not clear
    do_reset();
    wr(SVC, 8'h55);
    wr(SVC, 8'hAA);      // clears at edge 2
    repeat (20) step();
    wr(SVC, 8'hAA);      // not armed: no effect
    n = 23; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 66, "R2 arm dropped after clear", n, 66);

    // R8: clear exactly on the terminal edge
    do_reset();
    wr(SVC, 8'h55);
    while (m_cnt != lim_of(rate_sel) - 1) step();
    wr(SVC, 8'hAA);
    check(rst_req == 0, "R8 clear wins over terminal", int'(rst_req), 0);
    n = 0; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 64, "R8 full period after coincident clear", n, 64);

    // R7: disabled, no request for long
    wdog_en = 0;
    seen = 0;
    repeat (300) begin step(); if (rst_req) seen = 1; end
    check(seen == 0, "R7 disabled no request", int'(seen), 0);
    wdog_en = 1;
    n = 0; seen = 0;
    while (!seen && n < 200) begin step(); n++; seen = rst_req; end
    check(n == 64, "R7 counter held at zero while off", n, 64);

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 60000; i++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 499) == 0) wdog_en = ~wdog_en;
      if ($urandom_range(0, 1999) == 0) rate_sel = 2'($urandom_range(0, 3));
      if (r < 12) begin
        wr_en = 1;
        wr_addr = ($urandom_range(0, 9) < 7) ? SVC : 16'($urandom);
        case ($urandom_range(0, 2))
          0: wr_data = 8'h55;
          1: wr_data = 8'hAA;
          default: wr_data = 8'($urandom);
        endcase
      end else idle();
      step();
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule